// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the pending-event flags and the per-event enable mask for a small peripheral that has two timers and a serial shifter. Five event sources pulse one-cycle set strobes. The matching flag bit goes high and stays high until it is cleared. Software clears flags in two ways. It can write ones to the flag register through a byte-wide register port. It can also let another part of the peripheral pulse a clear mask, for example when a data or counter register is read.

Bit 7 of the enable register is not stored. On a write it chooses the operation: a 1 sets the enable bits written as one, and a 0 clears them. A read of the flag register puts a summary bit in bit 7 that says whether any pending flag is also enabled. Only the shifter-complete and the two timer positions drive the single level interrupt line. That line is registered.

The register port is a plain strobe interface with no valid/ready handshake. A write completes in the cycle it is presented, and read data is combinational from the register index. Nothing at this edge can stall, so there is no back-pressure.

Top module: `irq_flag_ctrl`

## Requirements
- R1: The set strobes map to these flag bits: `set_shift_done` to bit 2, `set_shift_data` to bit 3, `set_shift_clk` to bit 4, `set_tmr2` to bit 5 and `set_tmr1` to bit 6. A strobe sets its flag at the next clock edge. Flag bits 0 and 1 always read as 0.
- R2: A write to the enable register (index 14) with data bit 7 = 1 ORs data bits 6:0 into the enable bits.
- R3: A write to the enable register with data bit 7 = 0 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R4: A read of the enable register returns the enable bits 6:0, with bit 7 always 1.
- R5: A read of the flag register (index 13) returns flags 6:0 in bits 6:0. Bit 7 is 1 exactly when any flag bit and its enable bit are both 1, in any of bits 6:0.
- R6: A write to the flag register clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R7: `irq` is 1 exactly when, one clock earlier, flag AND enable was nonzero in bits 2, 5 or 6 (mask 0x64). The shift data and shift clock positions never drive `irq`.
- R8: After reset all flags and enables are 0, `irq` is 0, the flag register reads 0x00 and the enable register reads 0x80.
- R9: When a set strobe and a clear (a register write or `clr_mask`) hit the same flag in the same cycle, the flag ends up set.
- R10: Each `clr_mask` bit that is 1 clears the matching flag at the next clock edge.
- R11: Register indices other than 13 and 14 read as 0x00, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 4 | Register index for reads and writes |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| set_shift_done | input | 1 | Shifter full/empty event |
| set_shift_data | input | 1 | Shifter data event |
| set_shift_clk | input | 1 | Shifter clock event |
| set_tmr2 | input | 1 | Timer 2 event |
| set_tmr1 | input | 1 | Timer 1 event |
| clr_mask | input | 8 | Flag clear strobes coming from read side effects elsewhere |
| irq | output | 1 | Registered level interrupt |

## Verification
The assertions assume every set strobe and `clr_mask` bit is a synchronous pulse that is valid at the clock edge. They also assume a write is presented for exactly one cycle with a stable index. The bench drives every input just after the falling edge and holds it through the next rising edge. Randomized stretches freely mix strobes, clear masks and writes to both registers and to unused indices, including same-cycle set and clear on the same bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W      = 8;
  localparam int IDX_W       = 4;
  localparam int BIT_SHDONE  = 2;
  localparam int BIT_SHDATA  = 3;
  localparam int BIT_SHCLK   = 4;
  localparam int BIT_TMR2    = 5;
  localparam int BIT_TMR1    = 6;
  localparam int BIT_CTRL    = 7;
  localparam logic [DATA_W-1:0] SRC_MASK =
    (8'h1 << BIT_SHDONE) | (8'h1 << BIT_SHDATA) | (8'h1 << BIT_SHCLK) |
    (8'h1 << BIT_TMR2) | (8'h1 << BIT_TMR1);
  localparam logic [DATA_W-1:0] IRQ_MASK =
    (8'h1 << BIT_SHDONE) | (8'h1 << BIT_TMR2) | (8'h1 << BIT_TMR1);
  localparam logic [IDX_W-1:0] IDX_FLAG = 4'd13;
  localparam logic [IDX_W-1:0] IDX_EN   = 4'd14;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] SRC = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flag_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (SRC[i]) begin : g_src
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= set_vec[i] | (bit_q & ~clr_vec[i]);
      end
      assign flag_q[i] = bit_q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> flag_q[i]); // R9
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]); // R6
    end else begin : g_none
      assign flag_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  localparam int CTRL = W - 1;
  logic [W-2:0] bits_q;
  logic [W-2:0] bits_d;

  always_comb begin
    bits_d = bits_q;
    if (wr) begin
      if (wdata[CTRL]) bits_d = bits_q | wdata[W-2:0];
      else             bits_d = bits_q & ~wdata[W-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign en_q = {1'b0, bits_q};

  AST_EN_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[CTRL]) |=> ((en_q[W-2:0] & $past(wdata[W-2:0])) == $past(wdata[W-2:0]))); // R2
  AST_EN_CLR_AND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[CTRL]) |=> ((en_q[W-2:0] & $past(wdata[W-2:0])) == '0)); // R3
endmodule

// File: rtl/irqc_irq_gen.sv
module irqc_irq_gen #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flag_q,
  input  logic [W-1:0] en_q,
  output logic         summary,
  output logic         irq_q
);
  logic [W-1:0] live;
  assign live    = flag_q & en_q;
  assign summary = |live[W-2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(live & MASK);
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              set_shift_done,
  input  logic              set_shift_data,
  input  logic              set_shift_clk,
  input  logic              set_tmr2,
  input  logic              set_tmr1,
  input  logic [DATA_W-1:0] clr_mask,
  output logic              irq
);
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] flag_q;
  logic [DATA_W-1:0] en_q;
  logic              wr_flag;
  logic              wr_en;
  logic              summary;

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_SHDONE] = set_shift_done;
    set_vec[BIT_SHDATA] = set_shift_data;
    set_vec[BIT_SHCLK]  = set_shift_clk;
    set_vec[BIT_TMR2]   = set_tmr2;
    set_vec[BIT_TMR1]   = set_tmr1;
  end

  assign wr_flag = reg_wr && (reg_idx == IDX_FLAG);
  assign wr_en   = reg_wr && (reg_idx == IDX_EN);
  assign clr_vec = clr_mask | (wr_flag ? reg_wdata : '0);

  irqc_flag_bank #(.W(DATA_W), .SRC(SRC_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flag_q(flag_q)
  );

  irqc_enable_reg #(.W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(reg_wdata), .en_q(en_q)
  );

  irqc_irq_gen #(.W(DATA_W), .MASK(IRQ_MASK)) u_irq (
    .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .en_q(en_q),
    .summary(summary), .irq_q(irq)
  );

  always_comb begin
    case (reg_idx)
      IDX_FLAG: reg_rdata = {summary, flag_q[DATA_W-2:0]};
      IDX_EN:   reg_rdata = {1'b1, en_q[DATA_W-2:0]};
      default:  reg_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(flag_q & en_q & IRQ_MASK) != '0)); // R7
  AST_IRQ_FOLLOWS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q & en_q & IRQ_MASK) != '0) |-> irq); // R7
  AST_UNSOURCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr) |=> (flag_q[1:0] == 2'b00)); // R1
endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_idx;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       s_done, s_data, s_clk, s_t2, s_t1;
  logic [7:0] clr_mask;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int m_flag = 0;
  int m_en = 0;
  int m_irq = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .set_shift_done(s_done), .set_shift_data(s_data), .set_shift_clk(s_clk),
    .set_tmr2(s_t2), .set_tmr1(s_t1), .clr_mask(clr_mask), .irq(irq)
  );

  function automatic int model_read(input int idx);
    if (idx == 13) return (m_flag & 'h7f) | (((m_flag & m_en & 'h7f) != 0) ? 'h80 : 0);
    if (idx == 14) return (m_en & 'h7f) | 'h80;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One cycle: drive after falling edge, compare outputs, then step the model across the rising edge.
  task automatic step(input int idx, input bit wr, input int wd, input int sets,
                      input int clr, input string tag);
    int set_bits;
    int n_flag;
    int n_en;
    int n_irq;
    @(negedge clk);
    reg_idx = idx[3:0]; reg_wr = wr; reg_wdata = wd[7:0]; clr_mask = clr[7:0];
    {s_t1, s_t2, s_clk, s_data, s_done} = sets[4:0];
    #1;
    check({tag, " rdata"}, reg_rdata, model_read(idx));
    check({tag, " irq (R7)"}, irq, m_irq);
    set_bits = (sets & 'h1f) << 2;
    n_flag = m_flag & ~clr;
    if (wr && idx == 13) n_flag = n_flag & ~wd;
    n_flag = (n_flag | set_bits) & 'h7c;
    n_en = m_en;
    if (wr && idx == 14) n_en = (wd & 'h80) ? (m_en | (wd & 'h7f)) : (m_en & ~wd & 'h7f);
    n_irq = ((m_flag & m_en & 'h64) != 0) ? 1 : 0;
    @(posedge clk);
    m_flag = n_flag; m_en = n_en; m_irq = n_irq;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lfsr;
    rst_n = 1'b0; reg_idx = 0; reg_wr = 0; reg_wdata = 0; clr_mask = 0;
    {s_t1, s_t2, s_clk, s_data, s_done} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R8 reset state
    step(13, 0, 0, 0, 0, "R8");
    step(14, 0, 0, 0, 0, "R8");
    // R1 each source to its own bit
    for (int k = 0; k < 5; k++) begin
      step(13, 0, 0, 1 << k, 0, "R1");
      step(13, 0, 0, 0, 0, "R1");
      step(13, 1, 'hff, 0, 0, "R6");
    end
    // R2 enable set
    step(14, 1, 'he4, 0, 0, "R2");
    step(14, 0, 0, 0, 0, "R4");
    // R7 irq from timer 1 after enable
    step(13, 0, 0, 5'b10000, 0, "R7");
    step(13, 0, 0, 0, 0, "R5");
    step(13, 0, 0, 0, 0, "R7");
    // R3 clear enable of timer 1 only
    step(14, 1, 'h40, 0, 0, "R3");
    step(14, 0, 0, 0, 0, "R3");
    step(13, 0, 0, 0, 0, "R7");
    // R5 data event enabled: summary without irq
    step(14, 1, 'h88, 0, 0, "R2");
    step(13, 0, 0, 5'b00010, 0, "R5");
    step(13, 0, 0, 0, 0, "R5");
    step(13, 0, 0, 0, 0, "R7");
    // R6 write-one-clear leaves zero bits alone
    step(13, 0, 0, 5'b00101, 0, "R6");
    step(13, 1, 'h08, 0, 0, "R6");
    step(13, 0, 0, 0, 0, "R6");
    // R9 set beats write clear and side clear
    step(13, 1, 'h20, 5'b01000, 0, "R9");
    step(13, 0, 0, 5'b10000, 'h40, "R9");
    step(13, 0, 0, 0, 0, "R9");
    // R10 side clear
    step(13, 0, 0, 0, 'h24, "R10");
    step(13, 0, 0, 0, 0, "R10");
    // R11 other indices
    step(3, 1, 'hff, 0, 0, "R11");
    step(0, 1, 'hff, 0, 0, "R11");
    step(13, 0, 0, 0, 0, "R11");
    step(14, 0, 0, 0, 0, "R11");
    // mixed traffic
    lfsr = 'h1ace;
    for (int n = 0; n < 600; n++) begin
      int idx;
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hffff;
      idx = ((lfsr & 3) == 0) ? (lfsr >> 4) & 15 : (((lfsr >> 2) & 1) ? 14 : 13);
      step(idx, ((lfsr >> 3) & 3) == 0, (lfsr >> 5) & 'hff,
           ((lfsr >> 7) & 1) ? (lfsr >> 8) & 'h1f : 0,
           ((lfsr >> 13) & 1) ? (lfsr >> 2) & 'hff : 0, "R7 mix");
    end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule